// File: doc/BRIEF.md
# Flash Program/Erase Suspend Controller

This block models the internal state of a serial flash device while an array program or erase is in flight. It receives decoded command strobes (write enable, program, erase, suspend, resume, read) together with a sector address. It keeps an 8-bit flag status word, the write-enable latch, a busy indication and a read-data-valid flag. Operation lengths and the suspend latency are parameters, counted in clock cycles. The serial command shifter and the memory array are outside it.

A suspend request raises a per-operation pending bit at once, and the device halts only after the suspend latency. When the work left is no longer than that latency, the operation runs to its normal end instead and the pending bit drops at completion. While an erase is halted, the rest of the array can still be read, and it can host one nested program. The halted sector refuses reads and programs. A resume restarts the halted operation from its saved remaining count.

Top module: `flash_susp_ctrl`

## Requirements
- R1: A suspend accepted during a program sets flag bit 2 on the clock edge that samples it. Flag bits: 7 = ready, 6 = erase suspend pending, 4 = program failure, 2 = program suspend pending; the other bits read 0.
- R2: A suspend accepted during an erase sets flag bit 6 on the clock edge that samples it.
- R3: When the remaining count at the suspend edge exceeds SUSP_LAT, bit 7 and ready return SUSP_LAT edges after the suspend edge, and busy_o falls at the same time.
- R4: When the remaining count at the suspend edge is SUSP_LAT or less, the operation ends at its original time with bit 7 set and bits 2 and 6 cleared. A suspend on the final edge leaves the flags at 80h.
- R5: After reset the flags read 80h, and wel_o, busy_o and rd_valid_o are 0.
- R6: While an erase is suspended, a program with the latch set to any other sector runs for PROG_CYC edges with bit 6 held. The device then returns to the erase-suspended state with bit 7 set.
- R7: A read accepted when idle, or when suspended and outside the halted erase sector, raises rd_valid_o for the one cycle after its edge. A read of the halted erase sector leaves rd_valid_o at 0.
- R8: A program to the halted erase sector sets bit 4, starts nothing, and leaves wel_o unchanged.
- R9: A resume clears bit 7 on its edge. The operation then completes after the cycles it had left, so the total running time still equals PROG_CYC or ERASE_CYC, and bits 2 and 6 clear at the end.
- R10: A suspend when idle, when already suspended, or after a late suspend changes no flag bit.
- R11: A write-enable strobe sets wel_o when the device is not busy. Program and erase start only with wel_o at 1. An accepted start clears wel_o and bit 4; without the latch the command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Power-on reset, active low |
| wren_i | input | 1 | Write-enable command strobe |
| prog_i | input | 1 | Program command strobe |
| erase_i | input | 1 | Sector erase command strobe |
| susp_i | input | 1 | Suspend command strobe |
| resume_i | input | 1 | Resume command strobe |
| read_i | input | 1 | Read command strobe |
| sect_i | input | SECT_W | Sector address of the command |
| fsr_o | output | 8 | Flag status word |
| wel_o | output | 1 | Write-enable latch |
| busy_o | output | 1 | An operation is running or halting |
| rd_valid_o | output | 1 | Data of the last read is valid |

## Verification
The suspend strobe is swept over every cycle of both a program and an erase. The offsets run from the first cycle after the start to the final one. This separates the halting path, the late path that completes, and the boundary where the work left equals the latency or is a single cycle. For each halted case the bench resumes the operation and checks that the total running time is unchanged. A directed sequence inside one erase suspension compares reads and programs to the halted sector and to a neighbouring sector. It also covers programs without the latch and redundant suspends. These show whether the access rules depend on the address match and not on the command alone.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_PEND,
    ST_SUSP,
    ST_NEST
  } fsc_state_e;

  typedef enum logic {
    OP_PROG,
    OP_ERASE
  } fsc_op_e;

  localparam int unsigned FLG_READY    = 7;
  localparam int unsigned FLG_ERS_HOLD = 6;
  localparam int unsigned FLG_PRG_FAIL = 4;
  localparam int unsigned FLG_PRG_HOLD = 2;
  localparam logic [7:0]  FLG_RESET    = 8'h80;

  // A suspend is late when the work left fits inside the latency window.
  function automatic logic susp_is_late(input int unsigned left, input int unsigned lat);
    return left <= lat;
  endfunction

  // Work left once the latency window has been spent running.
  function automatic int unsigned left_after_halt(input int unsigned left, input int unsigned lat);
    return left - lat;
  endfunction

  // Flag bit that reports a pending suspend for a given operation kind.
  function automatic int unsigned hold_bit(input fsc_op_e kind);
    return (kind == OP_ERASE) ? FLG_ERS_HOLD : FLG_PRG_HOLD;
  endfunction

endpackage

// File: rtl/fsc_countdown.sv
module fsc_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == W'(1));

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (cnt_q != '0)); // R9

endmodule

// File: rtl/fsc_access_guard.sv
module fsc_access_guard
  import fsc_pkg::*;
#(
  parameter int SECT_W = 8
) (
  input  fsc_state_e        state,
  input  fsc_op_e           kind,
  input  logic [SECT_W-1:0] held_sect,
  input  logic [SECT_W-1:0] sect_i,
  input  logic              read_i,
  input  logic              prog_i,
  input  logic              wel,
  output logic              read_ok,
  output logic              nest_ok,
  output logic              prog_reject
);

  logic erase_held;
  logic sect_hit;

  always_comb begin
    erase_held  = (state == ST_SUSP) && (kind == OP_ERASE);
    sect_hit    = (sect_i == held_sect);
    read_ok     = read_i && ((state == ST_IDLE) ||
                             ((state == ST_SUSP) && !(erase_held && sect_hit)));
    prog_reject = prog_i && erase_held && sect_hit;
    nest_ok     = prog_i && wel && erase_held && !sect_hit;
  end

endmodule

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl
  import fsc_pkg::*;
#(
  parameter int SECT_W    = 8,
  parameter int PROG_CYC  = 200,
  parameter int ERASE_CYC = 2000,
  parameter int SUSP_LAT  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic              susp_i,
  input  logic              resume_i,
  input  logic              read_i,
  input  logic [SECT_W-1:0] sect_i,
  output logic [7:0]        fsr_o,
  output logic              wel_o,
  output logic              busy_o,
  output logic              rd_valid_o
);

  localparam int OP_MAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W  = $clog2(OP_MAX + 1);
  localparam int LAT_W  = $clog2(SUSP_LAT + 1);

  fsc_state_e        state_q;
  fsc_op_e           kind_q;
  logic [SECT_W-1:0] sect_q;
  logic              late_q;
  logic [7:0]        fsr_q;
  logic              wel_q;
  logic              rdv_q;
  logic [CNT_W-1:0]  exp_left_q;

  logic [CNT_W-1:0]  op_cnt;
  logic              op_last;
  logic              op_load;
  logic [CNT_W-1:0]  op_load_val;
  logic              op_dec;
  logic [LAT_W-1:0]  lat_cnt;
  logic              lat_last;
  logic              lat_dec;
  logic [CNT_W-1:0]  nest_cnt;
  logic              nest_last;
  logic              nest_dec;

  logic              read_ok;
  logic              nest_ok;
  logic              prog_reject;

  // Named events, shared by the state update and the assertions.
  logic    ev_start;
  fsc_op_e start_kind;
  logic    ev_susp_any;
  logic    susp_late;
  logic    ev_susp_accept;
  logic    ev_susp_late;
  logic    ev_susp_done;
  logic    ev_op_done;
  logic    ev_resume;
  logic    ev_nest_start;
  logic    ev_nest_done;
  logic    ev_reject;

  fsc_access_guard #(.SECT_W(SECT_W)) u_guard (
    .state       (state_q),
    .kind        (kind_q),
    .held_sect   (sect_q),
    .sect_i      (sect_i),
    .read_i      (read_i),
    .prog_i      (prog_i),
    .wel         (wel_q),
    .read_ok     (read_ok),
    .nest_ok     (nest_ok),
    .prog_reject (prog_reject)
  );

  always_comb begin
    start_kind     = erase_i ? OP_ERASE : OP_PROG;
    ev_start       = (state_q == ST_IDLE) && wel_q && (prog_i || erase_i);
    ev_susp_any    = (state_q == ST_RUN) && susp_i && !late_q;
    susp_late      = susp_is_late(int'(op_cnt), SUSP_LAT);
    ev_susp_accept = ev_susp_any && !susp_late;
    ev_susp_late   = ev_susp_any && susp_late;
    ev_susp_done   = (state_q == ST_PEND) && lat_last;
    ev_op_done     = (state_q == ST_RUN) && op_last;
    ev_resume      = (state_q == ST_SUSP) && resume_i;
    ev_nest_start  = nest_ok && !resume_i;
    ev_nest_done   = (state_q == ST_NEST) && nest_last;
    ev_reject      = prog_reject;
  end

  always_comb begin
    op_load     = ev_start;
    op_load_val = (start_kind == OP_ERASE) ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
    op_dec      = (state_q == ST_RUN) || ((state_q == ST_PEND) && !lat_last);
    lat_dec     = (state_q == ST_PEND);
    nest_dec    = (state_q == ST_NEST);
  end

  fsc_countdown #(.W(CNT_W)) u_op_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (op_load),
    .load_val (op_load_val),
    .dec      (op_dec),
    .cnt_o    (op_cnt),
    .last_o   (op_last)
  );

  fsc_countdown #(.W(LAT_W)) u_lat_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_susp_accept),
    .load_val (LAT_W'(SUSP_LAT)),
    .dec      (lat_dec),
    .cnt_o    (lat_cnt),
    .last_o   (lat_last)
  );

  fsc_countdown #(.W(CNT_W)) u_nest_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_nest_start),
    .load_val (CNT_W'(PROG_CYC)),
    .dec      (nest_dec),
    .cnt_o    (nest_cnt),
    .last_o   (nest_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      kind_q     <= OP_PROG;
      sect_q     <= '0;
      late_q     <= 1'b0;
      fsr_q      <= FLG_RESET;
      wel_q      <= 1'b0;
      rdv_q      <= 1'b0;
      exp_left_q <= '0;
    end else begin
      rdv_q <= read_ok;
      if (wren_i && ((state_q == ST_IDLE) || (state_q == ST_SUSP))) begin
        wel_q <= 1'b1;
      end
      if (ev_start) begin
        state_q <= ST_RUN;
        kind_q  <= start_kind;
        sect_q  <= sect_i;
        late_q  <= 1'b0;
        wel_q   <= 1'b0;
        fsr_q[FLG_READY]    <= 1'b0;
        fsr_q[FLG_PRG_FAIL] <= 1'b0;
      end
      if (ev_susp_late) begin
        late_q <= 1'b1;
        fsr_q[hold_bit(kind_q)] <= 1'b1;
      end
      if (ev_susp_accept) begin
        state_q    <= ST_PEND;
        exp_left_q <= CNT_W'(left_after_halt(int'(op_cnt), SUSP_LAT));
        fsr_q[hold_bit(kind_q)] <= 1'b1;
      end
      if (ev_op_done) begin
        state_q <= ST_IDLE;
        late_q  <= 1'b0;
        fsr_q[FLG_READY]    <= 1'b1;
        fsr_q[FLG_PRG_HOLD] <= 1'b0;
        fsr_q[FLG_ERS_HOLD] <= 1'b0;
      end
      if (ev_susp_done) begin
        state_q <= ST_SUSP;
        fsr_q[FLG_READY] <= 1'b1;
      end
      if (ev_resume) begin
        state_q <= ST_RUN;
        fsr_q[FLG_READY] <= 1'b0;
      end
      if (ev_nest_start) begin
        state_q <= ST_NEST;
        wel_q   <= 1'b0;
        fsr_q[FLG_READY]    <= 1'b0;
        fsr_q[FLG_PRG_FAIL] <= 1'b0;
      end
      if (ev_nest_done) begin
        state_q <= ST_SUSP;
        fsr_q[FLG_READY] <= 1'b1;
      end
      if (ev_reject) begin
        fsr_q[FLG_PRG_FAIL] <= 1'b1;
      end
    end
  end

  assign fsr_o      = fsr_q;
  assign wel_o      = wel_q;
  assign rd_valid_o = rdv_q;
  assign busy_o     = (state_q == ST_RUN) || (state_q == ST_PEND) || (state_q == ST_NEST);

  AST_PRG_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_susp_accept && (kind_q == OP_PROG)) |=> fsr_o[2]); // R1
  AST_ERS_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_susp_accept && (kind_q == OP_ERASE)) |=> fsr_o[6]); // R2
  AST_HALT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_susp_done |=> (fsr_o[7] && !busy_o)); // R3
  AST_LAT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PEND) |-> (lat_cnt != '0)); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_op_done |=> (fsr_o[7] && !fsr_o[6] && !fsr_o[2] && !busy_o)); // R4
  AST_NEST_KEEPS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NEST) |-> (fsr_o[6] && (nest_cnt != '0))); // R6
  AST_HELD_READ_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (read_i && (state_q == ST_SUSP) && (kind_q == OP_ERASE) && (sect_i == sect_q))
      |=> !rd_valid_o); // R7
  AST_REJECT_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_reject && !wren_i) |=> (fsr_o[4] && (wel_o == $past(wel_o)))); // R8
  AST_SAVED_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_susp_done |-> (op_cnt == exp_left_q)); // R9
  AST_IGNORED_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_i && ((state_q == ST_IDLE) || (state_q == ST_SUSP)) &&
     !prog_i && !erase_i && !resume_i) |=> $stable(fsr_o)); // R10
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !wel_o); // R11

endmodule

// File: tb/flash_susp_ctrl_test.sv
module flash_susp_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int SW         = 2;
  localparam int PC         = 12;
  localparam int EC         = 30;
  localparam int SL         = 5;
  localparam int WATCHDOG   = 100000;

  localparam int C_WREN = 0, C_PROG = 1, C_ERASE = 2, C_SUSP = 3, C_RES = 4, C_READ = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wren_i, prog_i, erase_i, susp_i, resume_i, read_i;
  logic [SW-1:0] sect_i;
  logic [7:0]    fsr_o;
  logic          wel_o, busy_o, rd_valid_o;

  int n_checks = 0;
  int n_errors = 0;

  flash_susp_ctrl #(
    .SECT_W(SW), .PROG_CYC(PC), .ERASE_CYC(EC), .SUSP_LAT(SL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .prog_i(prog_i), .erase_i(erase_i),
    .susp_i(susp_i), .resume_i(resume_i), .read_i(read_i), .sect_i(sect_i),
    .fsr_o(fsr_o), .wel_o(wel_o), .busy_o(busy_o), .rd_valid_o(rd_valid_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int flags(input bit ready, input bit ers, input bit prg, input bit fail);
    return (int'(ready) << 7) | (int'(ers) << 6) | (int'(fail) << 4) | (int'(prg) << 2);
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int cmd, input int sect);
    sect_i = SW'(sect);
    case (cmd)
      C_WREN:  wren_i   = 1'b1;
      C_PROG:  prog_i   = 1'b1;
      C_ERASE: erase_i  = 1'b1;
      C_SUSP:  susp_i   = 1'b1;
      C_RES:   resume_i = 1'b1;
      default: read_i   = 1'b1;
    endcase
    @(negedge clk);
    {wren_i, prog_i, erase_i, susp_i, resume_i, read_i} = '0;
  endtask

  // Start an operation, suspend it s edges after the start, finish it.
  task automatic run_case(input bit is_erase, input int s);
    int n    = is_erase ? EC : PC;
    int left = n - s + 1;
    string rq = is_erase ? "R2" : "R1";
    pulse(C_WREN, 0);
    check_eq("R11 latch set", int'(wel_o), 1);
    pulse(is_erase ? C_ERASE : C_PROG, s % 4);
    check_eq("R11 start", int'({busy_o, wel_o}), 2);
    repeat (s - 1) @(negedge clk);
    pulse(C_SUSP, 0);
    if (left == 1) begin
      check_eq("R4 final-edge suspend", int'(fsr_o), 8'h80);
    end else if (left <= SL) begin
      check_eq(rq, int'(fsr_o), flags(0, is_erase, !is_erase, 0));
      repeat (left - 2) @(negedge clk);
      check_eq("R4 still running", int'(busy_o), 1);
      @(negedge clk);
      check_eq("R4 late completes", int'({busy_o, fsr_o}), 8'h80);
    end else begin
      check_eq(rq, int'(fsr_o), flags(0, is_erase, !is_erase, 0));
      repeat (SL - 1) @(negedge clk);
      check_eq("R3 before latency", int'(fsr_o[7]), 0);
      @(negedge clk);
      check_eq("R3 halted", int'({busy_o, fsr_o}), flags(1, is_erase, !is_erase, 0));
      pulse(C_RES, 0);
      check_eq("R9 resumed", int'({busy_o, fsr_o}), 256 | flags(0, is_erase, !is_erase, 0));
      repeat (left - SL - 1) @(negedge clk);
      check_eq("R9 still running", int'(busy_o), 1);
      @(negedge clk);
      check_eq("R9 completes", int'({busy_o, fsr_o}), 8'h80);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    {wren_i, prog_i, erase_i, susp_i, resume_i, read_i} = '0;
    sect_i = '0;
    repeat (3) @(negedge clk);
    check_eq("R5 flags", int'(fsr_o), 8'h80);
    check_eq("R5 outputs", int'({wel_o, busy_o, rd_valid_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: suspend while idle, R11: program without the latch, R7: idle read
    pulse(C_SUSP, 0);
    check_eq("R10 idle suspend", int'(fsr_o), 8'h80);
    pulse(C_PROG, 1);
    check_eq("R11 no latch", int'({busy_o, fsr_o}), 8'h80);
    pulse(C_READ, 3);
    check_eq("R7 idle read", int'(rd_valid_o), 1);
    @(negedge clk);
    check_eq("R7 one cycle", int'(rd_valid_o), 0);

    for (int s = 1; s <= PC; s++) run_case(1'b0, s);
    for (int s = 1; s <= EC; s++) run_case(1'b1, s);

    // Directed: erase of sector 2 halted, access rules inside the suspension
    pulse(C_WREN, 0);
    pulse(C_ERASE, 2);
    pulse(C_SUSP, 0);
    repeat (SL) @(negedge clk);
    check_eq("R3 erase halted", int'(fsr_o), flags(1, 1, 0, 0));
    pulse(C_SUSP, 0);
    check_eq("R10 repeat suspend", int'(fsr_o), flags(1, 1, 0, 0));
    pulse(C_READ, 2);
    check_eq("R7 held sector read", int'(rd_valid_o), 0);
    pulse(C_READ, 1);
    check_eq("R7 other sector read", int'(rd_valid_o), 1);
    pulse(C_WREN, 0);
    pulse(C_PROG, 2);
    check_eq("R8 reject flags", int'({busy_o, fsr_o}), flags(1, 1, 0, 1));
    check_eq("R8 latch kept", int'(wel_o), 1);
    pulse(C_PROG, 0);
    check_eq("R6 nested start", int'({busy_o, wel_o, fsr_o}), 512 | flags(0, 1, 0, 0));
    repeat (PC - 1) @(negedge clk);
    check_eq("R6 nested running", int'(busy_o), 1);
    @(negedge clk);
    check_eq("R6 back to halted", int'({busy_o, fsr_o}), flags(1, 1, 0, 0));
    pulse(C_PROG, 1);
    check_eq("R11 nested no latch", int'({busy_o, fsr_o}), flags(1, 1, 0, 0));
    pulse(C_RES, 0);
    repeat (EC - SL - 1) @(negedge clk);
    check_eq("R9 erase running", int'(busy_o), 1);
    @(negedge clk);
    check_eq("R9 erase done", int'({busy_o, fsr_o}), 8'h80);

    // R10: suspend after a late suspend changes nothing
    pulse(C_WREN, 0);
    pulse(C_PROG, 0);
    repeat (PC - 4) @(negedge clk);
    pulse(C_SUSP, 0);
    pulse(C_SUSP, 0);
    check_eq("R10 second late suspend", int'(fsr_o), flags(0, 0, 1, 0));
    repeat (2) @(negedge clk);
    check_eq("R4 late done", int'({busy_o, fsr_o}), 8'h80);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule